// File: doc/BRIEF.md
# Scanline Sprite Evaluator

This block prepares the sprite layer of one video line. When `lineStart` is pulsed it latches the line number and two table base addresses. It then walks the sprite attribute table in video memory one entry at a time and keeps the sprites whose eight-line band contains the current line. For each kept sprite it fetches the matching 8-pixel pattern row. Once the walk has ended, it sweeps all 256 pixel positions to find overlapping opaque pixels, then pulses `lineDone`.

After `lineDone`, the pixel pipeline reads the sprite colour of any position. It drives `pixX` and gets `pixColor` back in the same cycle, and a colour of 0 means no sprite pixel. Two sticky flags and a sprite index are kept in `statusOut`. They are cleared by `statusClr`.

Memory is read through a simple port. `memRe` and `memAddr` are driven in one cycle, and `memData` must hold the byte in the next cycle.

Top module: `sprite_line_eval`

## Requirements
- R1: After reset, `statusOut` is 0, `lineDone` and `memRe` are low, and `pixColor` is 0 at every position.
- R2: Entry i of the attribute table occupies four bytes starting at `attrBase + 4*i`. The bytes are, at offsets 0 to 3: Y, X, pattern name, and colour, with the colour in bits 3:0. Entries 0 to 31 are examined in ascending order.
- R3: An entry whose Y byte is 0xD0 ends the walk. That entry and every later entry contribute nothing.
- R4: A sprite's top line is (Y + 1) mod 256, and it covers the eight lines starting there, with the count also wrapping mod 256. Y = 0xFF therefore puts the top row on line 0.
- R5: The pattern row shown is (line − top) mod 256. It is read from `patBase + name*8 + row`. Bit 7 is drawn at screen X and bit 0 at X+7. Positions past 255 are dropped and do not wrap to the left edge.
- R6: At most four covering sprites are drawn per line, namely the first four found in table order. Where their opaque pixels overlap, the lower-numbered entry's colour is output.
- R7: A sprite with colour 0 produces no pixel and takes part in no collision. It still uses one of the four slots.
- R8: When a fifth covering sprite is found, status bit 6 is set, status bits 4:0 take that entry's index, and the walk stops. While bit 6 remains set, later lines leave bits 6 and 4:0 unchanged.
- R9: Status bit 5 is set when opaque pixels of two drawn sprites share a screen position. The bit stays set until it is cleared.
- R10: A `statusClr` pulse while idle clears status bits 6, 5 and 4:0 at the next edge.
- R11: `lineDone` is a one-cycle pulse. The cycle count to reach it is fixed by the walk: 2 cycles for every examined entry that is not kept, 6 for every kept sprite, and 256 for the sweep. A `lineStart` that arrives during a line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Starts evaluation of a line (accepted when idle) |
| lineNum | input | 8 | Line to evaluate, sampled with `lineStart` |
| attrBase | input | ADDR_W | Attribute table base address |
| patBase | input | ADDR_W | Sprite pattern table base address |
| memRe | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | 8 | Read data, one cycle after `memRe` |
| pixX | input | 8 | Pixel position to look up |
| pixColor | output | 4 | Sprite colour at `pixX`, 0 when none |
| statusClr | input | 1 | Clears the status flags |
| statusOut | output | 8 | {0, fifth flag, collision flag, fifth index[4:0]} |
| lineDone | output | 1 | One-cycle pulse when the line is ready |

## Verification
Most internal faults appear in the cycle count. A walk that skips the sentinel test, miscounts slots, or ignores coverage changes the number of cycles before `lineDone`, and the bench compares that signal on every clock of every line. It therefore catches such faults at the first line whose table exercises them. A wrong row offset, bit order, clip or slot priority corrupts `pixColor` at specific positions, and a full 256-position sweep after each line finds it. Faults in the flags (stickiness, the fifth index, collision masking by colour 0) show in `statusOut` on the same `lineDone` cycle, and across consecutive lines with no clear between them.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

  localparam logic [7:0] SENTINEL_Y = 8'hD0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQY, ST_CAPY, ST_CAPX, ST_CAPN, ST_CAPC, ST_CAPP, ST_SCAN, ST_FIN
  } ctlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;
    logic       rdAttr;
    logic [1:0] fld;
    logic       rdPat;
    logic       capY;
    logic       capX;
    logic       capName;
    logic       capColor;
    logic       capRow;
    logic       nextIdx;
    logic       setFifth;
    logic       scanStep;
  } strobeT;

  // conditions from datapath to control
  typedef struct packed {
    logic sentinel;
    logic covers;
    logic full;
    logic lastIdx;
    logic scanLast;
  } dpFlagsT;

endpackage

// File: rtl/sprite_line_dp.sv
module sprite_line_dp
  import sprite_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SPR_N  = 32,
  parameter int SLOT_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        lineNum,
  input  logic [ADDR_W-1:0] attrBase,
  input  logic [ADDR_W-1:0] patBase,
  input  logic [7:0]        memData,
  input  logic [7:0]        pixX,
  input  logic              statusClr,
  input  strobeT            stb,
  output dpFlagsT           flags,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        pixColor,
  output logic [7:0]        statusOut
);

  localparam int IDX_W = $clog2(SPR_N);
  localparam int CNT_W = $clog2(SLOT_N + 1);

  logic [7:0]        lineQ;
  logic [ADDR_W-1:0] attrBaseQ, patBaseQ;
  logic [IDX_W-1:0]  idxQ;
  logic [CNT_W-1:0]  cntQ;
  logic [2:0]        rowQ;
  logic [7:0]        tmpX, tmpName;
  logic [3:0]        tmpColor;
  logic [7:0]        scanQ;
  logic              fifthQ, collQ;
  logic [4:0]        fifthIdxQ;

  logic [SLOT_N-1:0]       slotValid;
  logic [SLOT_N-1:0][7:0]  slotX;
  logic [SLOT_N-1:0][7:0]  slotPat;
  logic [SLOT_N-1:0][3:0]  slotCol;

  logic [7:0] topLine, rowDiff;
  logic [SLOT_N-1:0] pixHit, scanHit;

  // line coverage of the Y byte currently on memData
  always_comb begin
    topLine        = memData + 8'd1;
    rowDiff        = lineQ - topLine;
    flags.covers   = (rowDiff < 8'd8);
    flags.sentinel = (memData == SENTINEL_Y);
    flags.full     = (cntQ == CNT_W'(SLOT_N));
    flags.lastIdx  = (idxQ == IDX_W'(SPR_N - 1));
    flags.scanLast = (scanQ == 8'hFF);
  end

  // memory read port
  always_comb begin
    memRe   = stb.rdAttr | stb.rdPat;
    memAddr = stb.rdPat
            ? patBaseQ + ADDR_W'({tmpName, 3'b000}) + ADDR_W'(rowQ)
            : attrBaseQ + ADDR_W'({idxQ, stb.fld});
  end

  function automatic logic slotHit(input logic [7:0] px, input logic v,
                                   input logic [7:0] sx, input logic [7:0] pat,
                                   input logic [3:0] col);
    logic [8:0] d;
    d = {1'b0, px} - {1'b0, sx};
    return v && (col != 4'd0) && (d[8:3] == 6'd0) && pat[3'd7 - d[2:0]];
  endfunction

  for (genvar g = 0; g < SLOT_N; g++) begin : gSlotHit
    assign pixHit[g]  = slotHit(pixX,  slotValid[g], slotX[g], slotPat[g], slotCol[g]);
    assign scanHit[g] = slotHit(scanQ, slotValid[g], slotX[g], slotPat[g], slotCol[g]);
  end

  // lowest slot wins
  always_comb begin
    pixColor = 4'd0;
    for (int s = SLOT_N - 1; s >= 0; s--) begin
      if (pixHit[s]) pixColor = slotCol[s];
    end
  end

  assign statusOut = {1'b0, fifthQ, collQ, fifthIdxQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ     <= '0;
      attrBaseQ <= '0;
      patBaseQ  <= '0;
      idxQ      <= '0;
      cntQ      <= '0;
      rowQ      <= '0;
      tmpX      <= '0;
      tmpName   <= '0;
      tmpColor  <= '0;
      scanQ     <= '0;
      slotValid <= '0;
      slotX     <= '0;
      slotPat   <= '0;
      slotCol   <= '0;
    end else begin
      if (stb.start) begin
        lineQ     <= lineNum;
        attrBaseQ <= attrBase;
        patBaseQ  <= patBase;
        idxQ      <= '0;
        cntQ      <= '0;
        scanQ     <= '0;
        slotValid <= '0;
      end
      if (stb.capY)     rowQ     <= rowDiff[2:0];
      if (stb.capX)     tmpX     <= memData;
      if (stb.capName)  tmpName  <= memData;
      if (stb.capColor) tmpColor <= memData[3:0];
      if (stb.capRow) begin
        for (int s = 0; s < SLOT_N; s++) begin
          if (cntQ == CNT_W'(s)) begin
            slotValid[s] <= 1'b1;
            slotX[s]     <= tmpX;
            slotPat[s]   <= memData;
            slotCol[s]   <= tmpColor;
          end
        end
        cntQ <= cntQ + 1'b1;
      end
      if (stb.nextIdx)  idxQ  <= idxQ + 1'b1;
      if (stb.scanStep) scanQ <= scanQ + 8'd1;
    end
  end

  // status flags: a set in the same cycle overrides a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifthQ    <= 1'b0;
      collQ     <= 1'b0;
      fifthIdxQ <= '0;
    end else begin
      if (statusClr) begin
        fifthQ    <= 1'b0;
        collQ     <= 1'b0;
        fifthIdxQ <= '0;
      end
      if (stb.setFifth && !fifthQ) begin
        fifthQ    <= 1'b1;
        fifthIdxQ <= 5'(idxQ);
      end
      if (stb.scanStep && ($countones(scanHit) >= 2)) collQ <= 1'b1;
    end
  end

  a_r6_slot_room: assert property (@(posedge clk) disable iff (!rstN)
    stb.capRow |-> (cntQ < CNT_W'(SLOT_N)));

  a_r8_fifth_when_full: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFifth |-> (cntQ == CNT_W'(SLOT_N)));

  a_r8_fifth_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fifthQ && !statusClr) |=> (fifthQ && $stable(fifthIdxQ)));

  a_r9_coll_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (collQ && !statusClr) |=> collQ);

endmodule

// File: rtl/sprite_line_ctl.sv
module sprite_line_ctl
  import sprite_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineStart,
  input  dpFlagsT flags,
  output strobeT  stb,
  output logic    lineDone
);

  ctlStateT stateQ, stateD;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (lineStart) begin
        stb.start = 1'b1;
        stateD    = ST_REQY;
      end
      ST_REQY: begin
        stb.rdAttr = 1'b1;
        stb.fld    = 2'd0;
        stateD     = ST_CAPY;
      end
      ST_CAPY: begin
        stb.capY = 1'b1;
        if (flags.sentinel) begin
          stateD = ST_SCAN;
        end else if (flags.covers) begin
          if (flags.full) begin
            stb.setFifth = 1'b1;
            stateD       = ST_SCAN;
          end else begin
            stb.rdAttr = 1'b1;
            stb.fld    = 2'd1;
            stateD     = ST_CAPX;
          end
        end else if (flags.lastIdx) begin
          stateD = ST_SCAN;
        end else begin
          stb.nextIdx = 1'b1;
          stateD      = ST_REQY;
        end
      end
      ST_CAPX: begin
        stb.capX   = 1'b1;
        stb.rdAttr = 1'b1;
        stb.fld    = 2'd2;
        stateD     = ST_CAPN;
      end
      ST_CAPN: begin
        stb.capName = 1'b1;
        stb.rdAttr  = 1'b1;
        stb.fld     = 2'd3;
        stateD      = ST_CAPC;
      end
      ST_CAPC: begin
        stb.capColor = 1'b1;
        stb.rdPat    = 1'b1;
        stateD       = ST_CAPP;
      end
      ST_CAPP: begin
        stb.capRow = 1'b1;
        if (flags.lastIdx) begin
          stateD = ST_SCAN;
        end else begin
          stb.nextIdx = 1'b1;
          stateD      = ST_REQY;
        end
      end
      ST_SCAN: begin
        stb.scanStep = 1'b1;
        if (flags.scanLast) stateD = ST_FIN;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign lineDone = (stateQ == ST_FIN);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);

  a_r3_sentinel_stops: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capY && flags.sentinel) |-> !(stb.rdAttr || stb.nextIdx));

endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
  import sprite_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int SPR_N  = 32,
  parameter int SLOT_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [7:0]        lineNum,
  input  logic [ADDR_W-1:0] attrBase,
  input  logic [ADDR_W-1:0] patBase,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  input  logic [7:0]        pixX,
  output logic [3:0]        pixColor,
  input  logic              statusClr,
  output logic [7:0]        statusOut,
  output logic              lineDone
);

  strobeT  stb;
  dpFlagsT flags;

  sprite_line_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .flags     (flags),
    .stb       (stb),
    .lineDone  (lineDone)
  );

  sprite_line_dp #(
    .ADDR_W (ADDR_W),
    .SPR_N  (SPR_N),
    .SLOT_N (SLOT_N)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lineNum   (lineNum),
    .attrBase  (attrBase),
    .patBase   (patBase),
    .memData   (memData),
    .pixX      (pixX),
    .statusClr (statusClr),
    .stb       (stb),
    .flags     (flags),
    .memRe     (memRe),
    .memAddr   (memAddr),
    .pixColor  (pixColor),
    .statusOut (statusOut)
  );

endmodule

// File: tb/sim_sprite_line_eval.sv
module sim_sprite_line_eval;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 11;
  localparam int ATTR = 'h780;
  localparam int PAT  = 'h000;

  logic          clk = 1'b0;
  logic          rstN, lineStart, statusClr;
  logic [7:0]    lineNum, pixX, memData;
  logic [AW-1:0] attrBase, patBase, memAddr;
  logic          memRe, lineDone;
  logic [3:0]    pixColor;
  logic [7:0]    statusOut;

  logic [7:0] vmem [0:(1<<AW)-1];

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // model state
  int mFifth = 0, mColl = 0, mIdx = 0;
  int mCnt;
  int mX[4], mPat[4], mCol[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (memRe) memData <= vmem[memAddr];

  sprite_line_eval #(.ADDR_W(AW), .SPR_N(32), .SLOT_N(4)) u0 (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .lineNum(lineNum),
    .attrBase(attrBase), .patBase(patBase), .memRe(memRe), .memAddr(memAddr),
    .memData(memData), .pixX(pixX), .pixColor(pixColor), .statusClr(statusClr),
    .statusOut(statusOut), .lineDone(lineDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clearTable();
    for (int i = 0; i < 32; i++) begin
      vmem[ATTR+4*i]   = 8'hD0;
      vmem[ATTR+4*i+1] = 8'h00;
      vmem[ATTR+4*i+2] = 8'h00;
      vmem[ATTR+4*i+3] = 8'h00;
    end
  endtask

  task automatic setSpr(input int i, input int y, input int x, input int nm, input int col);
    vmem[ATTR+4*i]   = 8'(y);
    vmem[ATTR+4*i+1] = 8'(x);
    vmem[ATTR+4*i+2] = 8'(nm);
    vmem[ATTR+4*i+3] = 8'(col);
  endtask

  task automatic fillPat(input int nm, input int val);
    for (int r = 0; r < 8; r++) vmem[PAT+nm*8+r] = 8'(val);
  endtask

  function automatic int modelHit(input int s, input int x);
    int d;
    d = x - mX[s];
    if (mCol[s] == 0 || d < 0 || d > 7) return 0;
    return (mPat[s] >> (7 - d)) & 1;
  endfunction

  function automatic int modelPix(input int x);
    for (int s = 0; s < mCnt; s++) if (modelHit(s, x) != 0) return mCol[s];
    return 0;
  endfunction

  // evaluate one line in the model and against the design
  task automatic runLine(input int line, input string tag, input bit restart);
    int n, y, top, row, nm;
    n = 0;
    mCnt = 0;
    for (int i = 0; i < 32; i++) begin
      y = vmem[ATTR+4*i];
      n += 2;
      if (y == 'hD0) break;
      top = (y + 1) % 256;
      row = (line - top + 256) % 256;
      if (row < 8) begin
        if (mCnt == 4) begin
          if (mFifth == 0) begin mFifth = 1; mIdx = i; end
          break;
        end
        mX[mCnt]   = vmem[ATTR+4*i+1];
        nm         = vmem[ATTR+4*i+2];
        mCol[mCnt] = vmem[ATTR+4*i+3] & 15;
        mPat[mCnt] = vmem[PAT+nm*8+row];
        mCnt++;
        n += 4;
      end
    end
    n += 256;
    for (int x = 0; x < 256; x++) begin
      int c;
      c = 0;
      for (int s = 0; s < mCnt; s++) c += modelHit(s, x);
      if (c >= 2) mColl = 1;
    end

    @(negedge clk);
    lineNum   = 8'(line);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    for (int t = 1; t <= n + 1; t++) begin
      if (restart && t == 5) lineStart = 1'b1;
      if (restart && t == 6) lineStart = 1'b0;
      chk({tag, " R11 lineDone timing"}, int'(lineDone), (t == n + 1) ? 1 : 0);
      if (t != n + 1) @(negedge clk);
    end
    chk({tag, " R8 R9 status"}, int'(statusOut), (mFifth << 6) | (mColl << 5) | (mFifth ? mIdx : 0));
    for (int x = 0; x < 256; x++) begin
      pixX = 8'(x);
      #1;
      chk({tag, " R5 R6 pixel"}, int'(pixColor), modelPix(x));
      @(negedge clk);
    end
  endtask

  task automatic clearStatus();
    @(negedge clk);
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    mFifth = 0; mColl = 0; mIdx = 0;
    chk("R10 status cleared", int'(statusOut), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; lineStart = 1'b0; statusClr = 1'b0;
    lineNum = '0; pixX = '0;
    attrBase = AW'(ATTR); patBase = AW'(PAT);
    for (int a = 0; a < (1<<AW); a++) vmem[a] = 8'h00;
    clearTable();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 status", int'(statusOut), 0);
    chk("R1 lineDone", int'(lineDone), 0);
    chk("R1 memRe", int'(memRe), 0);
    for (int x = 0; x < 256; x += 37) begin
      pixX = 8'(x); #1;
      chk("R1 pixel", int'(pixColor), 0);
    end

    // R4 R5: Y=FF places top row on line 0
    fillPat(1, 'hFF);
    setSpr(0, 'hFF, 0, 1, 'hF);
    runLine(0, "R4 yff", 0);
    chk("R4 left pixel", modelPix(0), 'hF);

    // R4 wrap: Y=FC covers line 2 (row 5), not line 5
    clearTable();
    for (int r = 0; r < 8; r++) vmem[PAT+2*8+r] = 8'(1 << r);
    setSpr(0, 'hFC, 10, 2, 3);
    runLine(2, "R4 wrap", 0);
    runLine(5, "R4 below", 0);

    // R3 sentinel hides later entries
    clearTable();
    setSpr(1, 'hFF, 0, 1, 'hF);
    runLine(0, "R3 sentinel", 0);

    // R8 R6 five sprites, fifth index 4
    clearTable();
    for (int i = 0; i < 6; i++) setSpr(i, 'hFF, i*16, 1, i+1);
    runLine(0, "R8 fifth", 0);
    chk("R8 index", int'(statusOut[4:0]), 4);

    // R8 sticky: a later fifth at entry 7 leaves index 4
    clearTable();
    for (int i = 0; i < 3; i++) setSpr(i, 'h50, 0, 1, 2);
    for (int i = 3; i < 8; i++) setSpr(i, 'hFF, i*20, 1, 5);
    runLine(0, "R8 sticky", 0);
    chk("R8 sticky index", int'(statusOut[4:0]), 4);
    clearStatus();

    // R9 R6 collision and priority
    clearTable();
    fillPat(3, 'hF0);
    setSpr(0, 'hFF, 20, 3, 5);
    setSpr(1, 'hFF, 22, 1, 9);
    runLine(0, "R9 overlap", 0);
    chk("R6 priority", modelPix(22), 5);
    clearStatus();

    // R7 colour 0 transparent but occupies a slot
    clearTable();
    setSpr(0, 'hFF, 40, 1, 0);
    setSpr(1, 'hFF, 40, 1, 7);
    setSpr(2, 'hFF, 100, 1, 2);
    setSpr(3, 'hFF, 120, 1, 4);
    setSpr(4, 'hFF, 140, 1, 6);
    runLine(0, "R7 transparent", 0);
    chk("R7 no collision", int'(statusOut[5]), 0);
    chk("R7 fifth index", int'(statusOut[4:0]), 4);
    clearStatus();

    // R5 clip at right edge, no wrap to left
    clearTable();
    setSpr(0, 'hFF, 252, 1, 'hC);
    runLine(0, "R5 clip", 0);

    // R2 full walk of 32 entries, last entry kept; R11 restart ignored
    clearTable();
    for (int i = 0; i < 31; i++) setSpr(i, 'h80, 0, 1, 1);
    setSpr(31, 'hFF, 100, 3, 8);
    runLine(0, "R2 walk", 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule